// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block is an eight-line general-purpose I/O port with interrupt detection, reached through a small byte-wide register interface. Software sets each line as an input or an output and writes the value driven on output lines. Each input line can raise an interrupt on a level or on an edge, and software chooses the polarity. An optional debounce filter can be placed in front of the detector on each line.

Every pad input passes through a two-stage synchronizer. After that comes the per-line debounce filter and then the trigger logic. In level mode the request follows the filtered input directly. In edge mode a sticky pending bit records the chosen edge, and software clears it by writing ones to an end-of-interrupt register. The block drives eight per-line request outputs and one port request, which is the OR of the eight, so it can feed either a vectored or a shared interrupt input upstream.

Register writes take effect on the rising clock edge that samples `bus_we`. Reads are combinational from `bus_addr`. Offsets that are not decoded read as zero and ignore writes.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads zero. This covers direction, data latch, trigger kind, polarity, enable and debounce. All lines are inputs (`pin_oe` = 0), no pending edges are held, and `irq_line` and `irq_port` are 0.
- R2: A write to offset 0x10 sets direction, with 1 meaning output, and this drives `pin_oe`. A write to offset 0x00 sets the output latch, which drives `pin_out`. A read of 0x00 returns the latch bit for output lines and the synchronized pad bit for input lines.
- R3: A line with trigger-kind bit 0 (offset 0x90) is level sensitive. It requests while its filtered input equals its polarity bit (offset 0x94; 1 is high, 0 is low) and stops as soon as the input leaves that level. Nothing is latched.
- R4: A line with trigger-kind bit 1 is edge sensitive. Polarity 1 selects rising edges and polarity 0 selects falling edges. A detected edge sets a pending bit that keeps the request asserted after the input returns.
- R5: A write to offset 0x98 clears the pending bit of each line whose written bit is 1. Bits written as 0, including a write of 0x00, leave pending bits unchanged.
- R6: If an edge is detected on the same clock edge as an end-of-interrupt write for that line, the pending bit ends up set.
- R7: A line whose enable bit (offset 0x9C) is 0 never requests. While a line is disabled or in level mode its pending bit is held clear, so an edge seen while disabled does not appear after it is re-enabled.
- R8: When the line's debounce bit (offset 0xA8) is 1, the filtered input takes a new value only after the synchronized input has differed from the current value on 4 (parameter `DEB_TICKS`) consecutive clock edges. Shorter pulses are dropped. When the bit is 0, the synchronized input passes straight through.
- R9: A read of offset 0xA0 returns the per-line request vector, one bit per line.
- R10: `irq_port` is 1 exactly when at least one bit of `irq_line` is 1.
- R11: A pad change reaches a level-mode request after two rising clock edges, not after one. An edge-mode pending bit is set one clock edge later still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Asynchronous pad inputs |
| pin_out | output | 8 | Output latch value for the pads |
| pin_oe | output | 8 | Pad output enable, 1 means driven |
| irq_line | output | 8 | Per-line interrupt requests |
| irq_port | output | 1 | Combined port interrupt request |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` matter only while `bus_we` is high. They also assume that a clearing write and a change of trigger mode are separate events, so an edge-mode request can drop only after an end-of-interrupt write while the line stays armed. The pad inputs are treated as fully asynchronous. The stimulus changes pads and bus signals only on falling clock edges, holds `bus_we` for exactly one rising edge per access, and writes only decoded offsets. It places one end-of-interrupt write on the very edge where a synchronized edge arrives, and it sends glitches shorter than the debounce window.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int ADDR_W = 8;

   typedef logic [ADDR_W-1:0] reg_ofs_t;

   // Register offsets within the port's window
   localparam reg_ofs_t OFS_DATA   = 8'h00;
   localparam reg_ofs_t OFS_DIR    = 8'h10;
   localparam reg_ofs_t OFS_KIND   = 8'h90;
   localparam reg_ofs_t OFS_POL    = 8'h94;
   localparam reg_ofs_t OFS_EOI    = 8'h98;
   localparam reg_ofs_t OFS_EN     = 8'h9C;
   localparam reg_ofs_t OFS_STATUS = 8'hA0;
   localparam reg_ofs_t OFS_DEB    = 8'hA8;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
   parameter int TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic filt_en,
   input  logic d,
   output logic q
);

   localparam int CW = $clog2(TICKS);
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   initial begin
      assert (TICKS >= 2) else $error("gpio_debounce: TICKS must be at least 2");
   end

   logic          held_q;
   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         run_q  <= '0;
      end else if (!filt_en || (d == held_q)) begin
         held_q <= d;
         run_q  <= '0;
      end else if (run_q == LAST) begin
         held_q <= d;
         run_q  <= '0;
      end else begin
         run_q  <= run_q + 1'b1;
      end
   end

   assign q = filt_en ? held_q : d;

endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic line_en,
   input  logic edge_mode,
   input  logic active_high,
   input  logic eoi,
   output logic req
);

   logic prev_q;
   logic pend_q;
   logic armed;
   logic hit;

   assign armed = line_en & edge_mode;
   assign hit   = active_high ? (lvl & ~prev_q) : (~lvl & prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= lvl;
         if (!armed)   pend_q <= 1'b0;
         else if (hit) pend_q <= 1'b1;
         else if (eoi) pend_q <= 1'b0;
      end
   end

   assign req = line_en & (edge_mode ? pend_q : (lvl == active_high));

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int              NLINES      = 8,
   parameter int              SYNC_STAGES = 2,
   parameter int              DEB_TICKS   = 4,
   parameter logic [NLINES-1:0] DEB_MASK  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NLINES-1:0] bus_wdata,
   output logic [NLINES-1:0] bus_rdata,
   input  logic [NLINES-1:0] pin_in,
   output logic [NLINES-1:0] pin_out,
   output logic [NLINES-1:0] pin_oe,
   output logic [NLINES-1:0] irq_line,
   output logic              irq_port
);

   initial begin
      assert (NLINES >= 1 && NLINES <= 2**ADDR_W)
         else $error("gpio_irq_port: NLINES out of range");
      assert (DEB_TICKS >= 2)
         else $error("gpio_irq_port: DEB_TICKS must be at least 2");
   end

   logic [NLINES-1:0] out_q, dir_q, kind_q, pol_q, en_q, deb_q;
   logic [NLINES-1:0] pin_sync, lvl, eoi_clr;

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         kind_q <= '0;
         pol_q  <= '0;
         en_q   <= '0;
         deb_q  <= '0;
      end else if (bus_we) begin
         case (bus_addr)
            OFS_DATA: out_q  <= bus_wdata;
            OFS_DIR:  dir_q  <= bus_wdata;
            OFS_KIND: kind_q <= bus_wdata;
            OFS_POL:  pol_q  <= bus_wdata;
            OFS_EN:   en_q   <= bus_wdata;
            OFS_DEB:  deb_q  <= bus_wdata & DEB_MASK;
            default:  ;
         endcase
      end
   end

   assign eoi_clr = (bus_we && bus_addr == OFS_EOI) ? bus_wdata : '0;

   gpio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      if (DEB_MASK[i]) begin : g_filt
         gpio_debounce #(.TICKS(DEB_TICKS)) u_deb (
            .clk     (clk),
            .rst_n   (rst_n),
            .filt_en (deb_q[i]),
            .d       (pin_sync[i]),
            .q       (lvl[i])
         );
      end else begin : g_raw
         assign lvl[i] = pin_sync[i];
      end

      gpio_trigger u_trg (
         .clk         (clk),
         .rst_n       (rst_n),
         .lvl         (lvl[i]),
         .line_en     (en_q[i]),
         .edge_mode   (kind_q[i]),
         .active_high (pol_q[i]),
         .eoi         (eoi_clr[i]),
         .req         (irq_line[i])
      );
   end

   assign irq_port = |irq_line;
   assign pin_out  = out_q;
   assign pin_oe   = dir_q;

   // register reads
   always_comb begin
      case (bus_addr)
         OFS_DATA:   bus_rdata = (dir_q & out_q) | (~dir_q & pin_sync);
         OFS_DIR:    bus_rdata = dir_q;
         OFS_KIND:   bus_rdata = kind_q;
         OFS_POL:    bus_rdata = pol_q;
         OFS_EN:     bus_rdata = en_q;
         OFS_STATUS: bus_rdata = irq_line;
         OFS_DEB:    bus_rdata = deb_q;
         default:    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int NLINES = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [NLINES-1:0] bus_wdata,
   input logic [NLINES-1:0] pin_out,
   input logic [NLINES-1:0] pin_oe,
   input logic [NLINES-1:0] irq_line,
   input logic              irq_port,
   input logic [NLINES-1:0] kind_q,
   input logic [NLINES-1:0] en_q
);

   logic [NLINES-1:0] eoi_hit;
   assign eoi_hit = (bus_we && bus_addr == OFS_EOI) ? bus_wdata : '0;

   // R2: direction write reaches the pad enables on the next cycle
   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata)));

   // R2: data write reaches the pad outputs on the next cycle
   a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_DATA) |=> (pin_out == $past(bus_wdata)));

   // R7: clearing the whole enable register silences the port
   a_r7_all_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == OFS_EN && bus_wdata == '0) |=> !irq_port);

   // R10: combined request and per-line requests agree
   a_r10_port_or: assert property (@(posedge clk) disable iff (!rst_n)
      irq_port == ($countones(irq_line) != 0));

   // R4/R5: an armed edge-mode request only drops after an EOI for that line
   for (genvar i = 0; i < NLINES; i++) begin : g_sticky
      a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (kind_q[i] && en_q[i] && $past(kind_q[i] && en_q[i])
          && $past(irq_line[i]) && !irq_line[i]) |-> $past(eoi_hit[i]));
   end

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NLINES(NLINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq_line  (irq_line),
   .irq_port  (irq_port),
   .kind_q    (kind_q),
   .en_q      (en_q)
);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;

   localparam int DEB = 4;
   localparam logic [7:0] A_DATA = 8'h00, A_DIR = 8'h10, A_KIND = 8'h90, A_POL = 8'h94,
                          A_EOI = 8'h98, A_EN = 8'h9C, A_STAT = 8'hA0, A_DEB = 8'hA8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] pin_in = 8'h00;
   logic [7:0] pin_out, pin_oe, irq_line;
   logic       irq_port;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #5 clk = ~clk;

   gpio_irq_port dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_line(irq_line), .irq_port(irq_port)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_s1, m_s2, m_held, m_prev, m_pend;
   logic [7:0] m_out, m_dir, m_kind, m_pol, m_en, m_deb;
   int         m_cnt [8];
   logic [7:0] t_f, t_held, t_pend, t_eoi;
   int         t_cnt [8];

   function automatic logic [7:0] mdl_filt();
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[i] = m_deb[i] ? m_held[i] : m_s2[i];
      return r;
   endfunction

   function automatic logic [7:0] mdl_req();
      logic [7:0] r, f;
      f = mdl_filt();
      for (int i = 0; i < 8; i++)
         r[i] = m_en[i] && (m_kind[i] ? m_pend[i] : (f[i] == m_pol[i]));
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_held = 0; m_prev = 0; m_pend = 0;
         m_out = 0; m_dir = 0; m_kind = 0; m_pol = 0; m_en = 0; m_deb = 0;
         for (int i = 0; i < 8; i++) m_cnt[i] = 0;
      end else begin
         t_f   = mdl_filt();
         t_eoi = (bus_we && bus_addr == A_EOI) ? bus_wdata : 8'h00;
         for (int i = 0; i < 8; i++) begin
            // filter: accept a new value after DEB consecutive disagreeing samples
            if (!m_deb[i] || m_s2[i] == m_held[i]) begin
               t_held[i] = m_s2[i]; t_cnt[i] = 0;
            end else if (m_cnt[i] + 1 >= DEB) begin
               t_held[i] = m_s2[i]; t_cnt[i] = 0;
            end else begin
               t_held[i] = m_held[i]; t_cnt[i] = m_cnt[i] + 1;
            end
            if (!(m_en[i] && m_kind[i])) t_pend[i] = 1'b0;
            else if (m_pol[i] ? (t_f[i] && !m_prev[i]) : (!t_f[i] && m_prev[i])) t_pend[i] = 1'b1;
            else if (t_eoi[i]) t_pend[i] = 1'b0;
            else t_pend[i] = m_pend[i];
         end
         m_s2 = m_s1; m_s1 = pin_in;
         m_held = t_held; m_prev = t_f; m_pend = t_pend;
         for (int i = 0; i < 8; i++) m_cnt[i] = t_cnt[i];
         if (bus_we) begin
            case (bus_addr)
               A_DATA: m_out  = bus_wdata;
               A_DIR:  m_dir  = bus_wdata;
               A_KIND: m_kind = bus_wdata;
               A_POL:  m_pol  = bus_wdata;
               A_EN:   m_en   = bus_wdata;
               A_DEB:  m_deb  = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R11 model irq_line", irq_line, mdl_req());
         chk("R10 model irq_port", irq_port, |mdl_req());
         chk("R2 model pin_oe", pin_oe, m_dir);
         chk("R2 model pin_out", pin_out, m_out);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      waitn(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pin_oe", pin_oe, 8'h00);
      chk("R1 irq_port", irq_port, 1'b0);
      chk("R1 irq_line", irq_line, 8'h00);
      rd(A_DIR,  8'h00, "R1 dir");
      rd(A_DATA, 8'h00, "R1 data");
      rd(A_KIND, 8'h00, "R1 kind");
      rd(A_POL,  8'h00, "R1 pol");
      rd(A_EN,   8'h00, "R1 en");
      rd(A_DEB,  8'h00, "R1 deb");
      rd(A_STAT, 8'h00, "R1 status");

      // R2 direction and data
      wr(A_DIR, 8'h0F);
      wr(A_DATA, 8'hA5);
      chk("R2 pin_oe", pin_oe, 8'h0F);
      chk("R2 pin_out", pin_out, 8'hA5);
      pin_in = 8'h3C;
      waitn(3);
      rd(A_DATA, 8'h35, "R2 data readback mix");
      pin_in = 8'h00;
      wr(A_DIR, 8'h00);
      chk("R2 pin_oe cleared", pin_oe, 8'h00);
      waitn(3);

      // R3 level high on line 0, with R11 latency
      wr(A_POL, 8'h01);
      wr(A_EN, 8'h01);
      chk("R3 idle low", irq_line, 8'h00);
      @(negedge clk); pin_in = 8'h01;
      @(negedge clk); chk("R11 one edge not yet", irq_line, 8'h00);
      @(negedge clk); chk("R11 R3 after two edges", irq_line, 8'h01);
      chk("R10 port high", irq_port, 1'b1);
      rd(A_STAT, 8'h01, "R9 status");
      pin_in = 8'h00;
      waitn(3);
      chk("R3 no latch", irq_line, 8'h00);

      // R3 level low on line 1
      wr(A_EN, 8'h03);
      chk("R3 level low", irq_line, 8'h02);
      pin_in = 8'h02;
      waitn(3);
      chk("R3 level low released", irq_line, 8'h00);
      chk("R10 port low", irq_port, 1'b0);
      pin_in = 8'h00;
      wr(A_EN, 8'h00);
      waitn(3);

      // R4 edges: line 2 rising, line 3 falling
      wr(A_KIND, 8'h0C);
      wr(A_POL, 8'h04);
      wr(A_EN, 8'h0C);
      pin_in = 8'h04; waitn(4);
      chk("R4 rising latched", irq_line, 8'h04);
      pin_in = 8'h00; waitn(4);
      chk("R4 sticky after return", irq_line, 8'h04);
      pin_in = 8'h08; waitn(4);
      chk("R4 wrong edge ignored", irq_line, 8'h04);
      pin_in = 8'h00; waitn(4);
      chk("R4 falling latched", irq_line, 8'h0C);
      rd(A_STAT, 8'h0C, "R9 status two lines");

      // R5 EOI
      wr(A_EOI, 8'h08);
      chk("R5 clear line3 only", irq_line, 8'h04);
      wr(A_EOI, 8'h00);
      chk("R5 zero write no effect", irq_line, 8'h04);
      wr(A_EOI, 8'h04);
      chk("R5 clear line2", irq_line, 8'h00);
      chk("R10 port idle", irq_port, 1'b0);

      // R6 edge arriving with EOI wins
      @(negedge clk); pin_in = 8'h04;
      @(negedge clk);
      @(negedge clk); bus_we = 1'b1; bus_addr = A_EOI; bus_wdata = 8'h04;
      @(negedge clk); bus_we = 1'b0;
      chk("R6 edge beats eoi", irq_line, 8'h04);
      wr(A_EOI, 8'h04);
      chk("R6 later eoi clears", irq_line, 8'h00);
      pin_in = 8'h00; waitn(4);

      // R7 enable gating
      pin_in = 8'h04; waitn(4);
      chk("R7 pending before disable", irq_line, 8'h04);
      wr(A_EN, 8'h00);
      chk("R7 disabled silent", irq_line, 8'h00);
      pin_in = 8'h00; waitn(4);
      pin_in = 8'h04; waitn(4);
      wr(A_EN, 8'h0C);
      chk("R7 no stale pending", irq_line, 8'h00);
      pin_in = 8'h00; waitn(4);
      wr(A_EN, 8'h00);

      // R8 debounce on line 4, level high
      wr(A_KIND, 8'h00);
      wr(A_POL, 8'h10);
      wr(A_DEB, 8'h10);
      rd(A_DEB, 8'h10, "R8 deb readback");
      wr(A_EN, 8'h10);
      chk("R8 idle", irq_line, 8'h00);
      @(negedge clk); pin_in = 8'h10;
      @(negedge clk);
      @(negedge clk); pin_in = 8'h00;
      waitn(8);
      chk("R8 glitch dropped", irq_line, 8'h00);
      @(negedge clk); pin_in = 8'h10;
      waitn(5);
      chk("R8 still filtered", irq_line, 8'h00);
      @(negedge clk);
      chk("R8 accepted after window", irq_line, 8'h10);
      wr(A_DEB, 8'h00);
      @(negedge clk); pin_in = 8'h00;
      waitn(2);
      chk("R8 bypass follows sync", irq_line, 8'h00);
      wr(A_EN, 8'h00);
      waitn(2);

      finish_run();
   end

endmodule